// File: doc/BRIEF.md
# FP8 to BF16 Widening Converter

This unit takes one 128-bit source vector and widens eight 8-bit floating-point elements into eight BF16 results. The eight elements come from either the lower eight bytes or the upper eight bytes of the source. A 32-bit mode word holds two operand slots. Each slot has a 3-bit format code and a scale field. A slot-select input decides which slot applies to the current operation. Each converted value is multiplied by two to the power of minus the selected scale.

Operations enter through a valid/ready handshake. Each result, its exception flags and an undefined-operation indication appear in registers one cycle after acceptance. They are held there until the consumer takes them. A sticky flag register ORs together the flags of every operation that completes. If the mode word is not accessible, the operation produces no data and raises the undefined indication instead.

The scale only ever shrinks a value, and every 8-bit input fits with room to spare in the BF16 exponent range. As a result, every conversion is exact, and NaN handling is the only source of exceptions.

Top module: `fp8w_widen`

## Requirements
- R1: Format code 0 selects E5M2 and code 1 selects E4M3. Finite inputs, including subnormals, convert exactly.
  - E5M2 layout: sign bit 7, exponent bits 6:2 with bias 15, mantissa bits 1:0. Exponent 31 with a zero mantissa is infinity. Exponent 31 with any other mantissa is NaN.
  - E4M3 layout: sign bit 7, exponent bits 6:3 with bias 7, mantissa bits 2:0. It has no infinity. Only exponent 15 with mantissa 7 is NaN.
  - BF16 result layout: sign bit 15, exponent bits 14:7 with bias 127, fraction bits 6:0.
- R2: Format codes 2 to 7 are unsupported. With an unsupported code, all eight lanes return 16'h7FC0 and the invalid flag is set.
- R3: The mode word has this layout:
  - Slot 0: format at bits 2:0, scale field at bits 15:8.
  - Slot 1: format at bits 5:3, scale field at bits 23:16.
  - `slot_sel`=0 uses slot 0 and `slot_sel`=1 uses slot 1. The other slot has no effect.
- R4: The scale amount k is the low 6 bits of the selected scale field. Bits 7:6 of that field are ignored. Each finite result equals the input times 2^-k. Zeros and infinities keep their sign and are not changed by the scale.
- R5: With `hi_half`=0, lane i reads source byte i (`src_vec[8i+7:8i]`). With `hi_half`=1, lane i reads byte i+8. Lane i always writes `out_data[16i+15:16i]`.
- R6: Every NaN result is 16'h7FC0.
  - An E5M2 signalling NaN (exponent 31, mantissa bit 1 clear, mantissa not zero) raises the invalid flag.
  - Quiet E5M2 NaNs and E4M3 NaNs do not raise it.
- R7: The flag vector has this bit order: [0] invalid, [1] overflow, [2] underflow, [3] inexact, [4] input-denormal.
  - Bits 4:1 are always 0, because results are never flushed or rounded.
  - The input-denormal indication is never reported.
- R8: `out_data` bits above 127 are always zero.
- R9: If an operation is accepted while `mode_access_en`=0, the output shows `out_undef`=1, all-zero data and all-zero flags. The sticky register is left unchanged.
- R10: The handshake works as follows:
  - `in_ready` is high exactly when no result is pending or `out_ready` is high.
  - A result appears one cycle after acceptance.
  - A result is held, unchanged, while `out_valid`=1 and `out_ready`=0.
- R11: Reset clears `out_valid`, `out_data`, `out_flags`, `out_undef` and `sticky_flags`. After reset, the sticky register ORs in the flags of every accepted operation that is not undefined. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation |
| src_vec | input | 128 | Source vector of sixteen 8-bit elements |
| hi_half | input | 1 | Use upper eight source bytes |
| slot_sel | input | 1 | Operand slot whose format and scale apply |
| mode_cfg | input | 32 | Mode word holding both slots |
| mode_access_en | input | 1 | Mode word may be read by this operation |
| out_ready | input | 1 | Consumer takes the pending result |
| out_valid | output | 1 | Result pending |
| out_data | output | 256 | Eight BF16 lanes; upper bits zero |
| out_flags | output | 5 | Exception flags of this result |
| out_undef | output | 1 | Operation was undefined |
| sticky_flags | output | 5 | Accumulated flags |

## Verification
Some properties are checked by the assertions on every cycle:
- Undefined results carry no data and no flags.
- The overflow, underflow, inexact and input-denormal flags never rise.
- An unsupported format always yields eight default NaNs with the invalid flag set.
- Stalled results stay stable.
- The sticky register never loses a bit and always contains the flags of the current result.

Other behaviour can only be shown by the bench's scenarios. This covers the exact BF16 values for normal, subnormal, signed-zero, infinity and NaN inputs in both formats, the effect of scale 0, 5 and 63 (including the ignored upper bits of the scale field), the mapping of the lower and upper halves, and the way one slot is picked while the other holds nonsense.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

   localparam int MODE_W       = 32;
   localparam int FMT_W        = 3;
   localparam int SCL_FIELD_W  = 8;
   localparam int FMT0_LSB     = 0;
   localparam int FMT1_LSB     = 3;
   localparam int SCL0_LSB     = 8;
   localparam int SCL1_LSB     = 16;

   localparam logic [FMT_W-1:0] FMT_E5M2 = 3'd0;
   localparam logic [FMT_W-1:0] FMT_E4M3 = 3'd1;

   localparam logic [15:0] BF16_DNAN = 16'h7FC0;

   localparam int FLG_W   = 5;
   localparam int FLG_INV = 0;

   typedef enum logic [2:0] {
      K_ZERO,
      K_NORM,
      K_INF,
      K_QNAN,
      K_SNAN
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic       sgn;
      logic [7:0] bexp;   // BF16-biased exponent before scaling
      logic [6:0] frac;
   } parts_t;

   function automatic parts_t dec_e5m2(input logic [7:0] b);
      parts_t p;
      p.sgn  = b[7];
      p.kind = K_ZERO;
      p.bexp = '0;
      p.frac = '0;
      if (b[6:2] == 5'h1F) begin
         if (b[1:0] == 2'b00)  p.kind = K_INF;
         else if (b[1])        p.kind = K_QNAN;
         else                  p.kind = K_SNAN;
      end else if (b[6:2] != 5'h00) begin
         p.kind = K_NORM;
         p.bexp = {3'b000, b[6:2]} + 8'd112;
         p.frac = {b[1:0], 5'b00000};
      end else if (b[1]) begin
         p.kind = K_NORM;
         p.bexp = 8'd112;
         p.frac = {b[0], 6'b000000};
      end else if (b[0]) begin
         p.kind = K_NORM;
         p.bexp = 8'd111;
      end
      return p;
   endfunction

   function automatic parts_t dec_e4m3(input logic [7:0] b);
      parts_t p;
      p.sgn  = b[7];
      p.kind = K_ZERO;
      p.bexp = '0;
      p.frac = '0;
      if (b[6:0] == 7'h7F) begin
         p.kind = K_QNAN;
      end else if (b[6:3] != 4'h0) begin
         p.kind = K_NORM;
         p.bexp = {4'b0000, b[6:3]} + 8'd120;
         p.frac = {b[2:0], 4'b0000};
      end else if (b[2]) begin
         p.kind = K_NORM;
         p.bexp = 8'd120;
         p.frac = {b[1:0], 5'b00000};
      end else if (b[1]) begin
         p.kind = K_NORM;
         p.bexp = 8'd119;
         p.frac = {b[0], 6'b000000};
      end else if (b[0]) begin
         p.kind = K_NORM;
         p.bexp = 8'd118;
      end
      return p;
   endfunction

endpackage

// File: rtl/fp8w_cfg_sel.sv
module fp8w_cfg_sel
   import fp8w_pkg::*;
#(
   parameter int SCALE_W = 6
) (
   input  logic [MODE_W-1:0]  mode_cfg_i,
   input  logic               slot_i,
   output logic               fmt_ok_o,
   output logic               is_e4m3_o,
   output logic [SCALE_W-1:0] k_o
);

   logic [FMT_W-1:0]       fmt;
   logic [SCL_FIELD_W-1:0] sfield;

   assign fmt    = slot_i ? mode_cfg_i[FMT1_LSB +: FMT_W]
                          : mode_cfg_i[FMT0_LSB +: FMT_W];
   assign sfield = slot_i ? mode_cfg_i[SCL1_LSB +: SCL_FIELD_W]
                          : mode_cfg_i[SCL0_LSB +: SCL_FIELD_W];

   assign fmt_ok_o  = (fmt == FMT_E5M2) || (fmt == FMT_E4M3);
   assign is_e4m3_o = (fmt == FMT_E4M3);
   assign k_o       = sfield[SCALE_W-1:0];

   // Bits outside the two slots, and scale bits above SCALE_W, carry no meaning.
   logic unused_gap;
   assign unused_gap = ^{mode_cfg_i[SCL0_LSB-1:FMT1_LSB+FMT_W],
                         mode_cfg_i[MODE_W-1:SCL1_LSB+SCL_FIELD_W]};

   if (SCALE_W < SCL_FIELD_W) begin : g_scale_hi
      logic unused_scale_hi;
      assign unused_scale_hi = ^sfield[SCL_FIELD_W-1:SCALE_W];
   end

endmodule

// File: rtl/fp8w_lane.sv
module fp8w_lane
   import fp8w_pkg::*;
#(
   parameter int SCALE_W = 6
) (
   input  logic [7:0]         byte_i,
   input  logic               is_e4m3_i,
   input  logic [SCALE_W-1:0] k_i,
   output logic [15:0]        res_o,
   output logic               snan_o
);

   parts_t     p;
   logic [7:0] sexp;

   always_comb begin
      p = is_e4m3_i ? dec_e4m3(byte_i) : dec_e5m2(byte_i);
   end

   // Lowest reachable exponent stays well above the BF16 normal limit.
   assign sexp = p.bexp - {{(8-SCALE_W){1'b0}}, k_i};

   always_comb begin
      case (p.kind)
         K_NORM:  res_o = {p.sgn, sexp, p.frac};
         K_INF:   res_o = {p.sgn, 8'hFF, 7'h00};
         K_QNAN,
         K_SNAN:  res_o = BF16_DNAN;
         default: res_o = {p.sgn, 15'h0000};
      endcase
   end

   assign snan_o = (p.kind == K_SNAN);

endmodule

// File: rtl/fp8w_widen.sv
module fp8w_widen
   import fp8w_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int DEST_W  = 256,
   parameter int SCALE_W = 6,
   localparam int SRC_W  = 2 * LANES * 8,
   localparam int RES_W  = LANES * 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SRC_W-1:0]  src_vec,
   input  logic              hi_half,
   input  logic              slot_sel,
   input  logic [MODE_W-1:0] mode_cfg,
   input  logic              mode_access_en,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DEST_W-1:0] out_data,
   output logic [FLG_W-1:0]  out_flags,
   output logic              out_undef,
   output logic [FLG_W-1:0]  sticky_flags
);

   if (SCALE_W < 1 || SCALE_W > 6) begin : g_bad_scale
      $error("SCALE_W must lie in 1..6 to keep every result exact");
   end
   if (DEST_W < RES_W) begin : g_bad_dest
      $error("DEST_W must hold all lanes");
   end

   logic               fmt_ok;
   logic               is_e4m3;
   logic [SCALE_W-1:0] k;
   logic [RES_W-1:0]   lane_res;
   logic [LANES-1:0]   lane_snan;
   logic [RES_W-1:0]   nxt_res;
   logic [FLG_W-1:0]   nxt_flg;
   logic [RES_W-1:0]   res_q;
   logic               accept;

   fp8w_cfg_sel #(.SCALE_W(SCALE_W)) u_cfg (
      .mode_cfg_i (mode_cfg),
      .slot_i     (slot_sel),
      .fmt_ok_o   (fmt_ok),
      .is_e4m3_o  (is_e4m3),
      .k_o        (k)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] b;
      assign b = hi_half ? src_vec[(LANES+i)*8 +: 8] : src_vec[i*8 +: 8];
      fp8w_lane #(.SCALE_W(SCALE_W)) u_lane (
         .byte_i    (b),
         .is_e4m3_i (is_e4m3),
         .k_i       (k),
         .res_o     (lane_res[i*16 +: 16]),
         .snan_o    (lane_snan[i])
      );
   end

   always_comb begin
      nxt_flg = '0;
      if (fmt_ok) begin
         nxt_res          = lane_res;
         nxt_flg[FLG_INV] = |lane_snan;
      end else begin
         nxt_res          = {LANES{BF16_DNAN}};
         nxt_flg[FLG_INV] = 1'b1;
      end
   end

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         res_q        <= '0;
         out_flags    <= '0;
         out_undef    <= 1'b0;
         sticky_flags <= '0;
      end else if (accept) begin
         out_valid <= 1'b1;
         if (mode_access_en) begin
            res_q        <= nxt_res;
            out_flags    <= nxt_flg;
            out_undef    <= 1'b0;
            sticky_flags <= sticky_flags | nxt_flg;
         end else begin
            res_q     <= '0;
            out_flags <= '0;
            out_undef <= 1'b1;
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   if (DEST_W > RES_W) begin : g_pad
      assign out_data = {{(DEST_W-RES_W){1'b0}}, res_q};
   end else begin : g_nopad
      assign out_data = res_q;
   end

endmodule

// File: rtl/fp8w_widen_chk.sv
module fp8w_widen_chk
   import fp8w_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int DEST_W = 256,
   localparam int RES_W = LANES * 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              slot_sel,
   input logic [MODE_W-1:0] mode_cfg,
   input logic              mode_access_en,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DEST_W-1:0] out_data,
   input logic [FLG_W-1:0]  out_flags,
   input logic              out_undef,
   input logic [FLG_W-1:0]  sticky_flags
);

   logic [FMT_W-1:0] chk_fmt;
   logic             chk_take;
   assign chk_fmt  = slot_sel ? mode_cfg[5:3] : mode_cfg[2:0];
   assign chk_take = in_valid && in_ready;

   logic unused_chk;
   assign unused_chk = ^mode_cfg[MODE_W-1:6];
   if (DEST_W > RES_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^out_data[DEST_W-1:RES_W];
   end

   AST_BADFMT_DNAN: assert property (@(posedge clk) disable iff (!rst_n) chk_take && mode_access_en && (chk_fmt > 3'd1) |=> out_valid && out_flags[0] && (out_data[RES_W-1:0] == {LANES{BF16_DNAN}})); // R2
   AST_EXACT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_flags[4:1] == 4'b0000)); // R7
   AST_UNDEF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_undef |-> (out_data == '0) && (out_flags == '0)); // R9
   AST_UNDEF_NEXT: assert property (@(posedge clk) disable iff (!rst_n) chk_take && !mode_access_en |=> out_valid && out_undef); // R9
   AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) chk_take && mode_access_en |=> out_valid && !out_undef); // R10
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flags) && $stable(out_undef)); // R10
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (($past(sticky_flags) & ~sticky_flags) == '0)); // R11
   AST_STICKY_HAS: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_undef |-> ((out_flags & ~sticky_flags) == '0)); // R11

endmodule

bind fp8w_widen fp8w_widen_chk #(.LANES(LANES), .DEST_W(DEST_W)) u_chk (.*);

// File: tb/fp8w_widen_tb.sv
module fp8w_widen_tb;
   import fp8w_pkg::*;

   localparam int CLK_PERIOD  = 10;
   localparam int WDOG_CYCLES = 5000;
   localparam int LANES       = 8;
   localparam int DEST_W      = 256;
   localparam int SRC_W       = 128;
   localparam int RES_W       = 128;
   localparam int NVEC        = 8;

   typedef struct packed {
      logic [31:0]  mode;
      logic         slot;
      logic         hi;
      logic         acc;
      logic [127:0] src;
      logic [127:0] expd;
      logic [4:0]   flg;
      logic         undef;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_0000, 1'b0, 1'b0, 1'b1, {64'h1111111111111111, 64'h7E030180007CC03C},
        128'h7FC0_3840_3780_8000_0000_7F80_C000_3F80, 5'b00000, 1'b0},
      '{32'h0000_3F0D, 1'b1, 1'b1, 1'b1, {64'hFF0301047F7EB838, 64'h2222222222222222},
        128'h7FC0_3BC0_3B00_3C00_7FC0_43E0_BF80_3F80, 5'b00000, 1'b0},
      '{32'h0000_C500, 1'b0, 1'b0, 1'b1, {64'h3333333333333333, 64'h004580027DFC7B3C},
        128'h0000_3E20_8000_3580_7FC0_FF80_44E0_3D00, 5'b00001, 1'b0},
      '{32'h0000_3F01, 1'b0, 1'b0, 1'b1, {64'h4444444444444444, 64'h000000C8807E3801},
        128'h0000_0000_0000_A100_8000_2460_2000_1B80, 5'b00000, 1'b0},
      '{32'h0000_0038, 1'b1, 1'b0, 1'b1, {64'h0, 64'h3C3C3C3C3C3C3C3C},
        {8{16'h7FC0}}, 5'b00001, 1'b0},
      '{32'h0001_0002, 1'b1, 1'b1, 1'b1, {64'h3C3C3C3CFD3C3C3C, 64'h0},
        128'h3F00_3F00_3F00_3F00_7FC0_3F00_3F00_3F00, 5'b00001, 1'b0},
      '{32'h0000_0004, 1'b0, 1'b0, 1'b1, {64'h0, 64'h3C3C3C3C3C3C3C3C},
        {8{16'h7FC0}}, 5'b00001, 1'b0},
      '{32'h0000_0000, 1'b0, 1'b0, 1'b0, {64'h0, 64'h3C3C3C3C3C3C3C3C},
        128'h0, 5'b00000, 1'b1}
   };

   localparam string TAGS [NVEC] = '{
      "R1 R5 R6 R7", "R1 R3 R5 R6", "R4 R6 R7", "R4 R7",
      "R2 R3", "R3 R4 R5 R6", "R2", "R9"
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [SRC_W-1:0]  src_vec = '0;
   logic              hi_half = 1'b0;
   logic              slot_sel = 1'b0;
   logic [31:0]       mode_cfg = '0;
   logic              mode_access_en = 1'b1;
   logic              out_ready = 1'b1;
   logic              out_valid;
   logic [DEST_W-1:0] out_data;
   logic [4:0]        out_flags;
   logic              out_undef;
   logic [4:0]        sticky_flags;

   int   total = 0;
   int   bad   = 0;
   logic done  = 1'b0;
   logic [4:0] exp_sticky = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp8w_widen #(.LANES(LANES), .DEST_W(DEST_W), .SCALE_W(6)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_ready       (in_ready),
      .src_vec        (src_vec),
      .hi_half        (hi_half),
      .slot_sel       (slot_sel),
      .mode_cfg       (mode_cfg),
      .mode_access_en (mode_access_en),
      .out_ready      (out_ready),
      .out_valid      (out_valid),
      .out_data       (out_data),
      .out_flags      (out_flags),
      .out_undef      (out_undef),
      .sticky_flags   (sticky_flags)
   );

   task automatic check(input string req, input string what,
                        input logic [255:0] act, input logic [255:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic drive(input vec_t v);
      mode_cfg       = v.mode;
      slot_sel       = v.slot;
      hi_half        = v.hi;
      mode_access_en = v.acc;
      src_vec        = v.src;
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state, R11
      repeat (3) @(negedge clk);
      check("R11", "reset out_valid", 256'(out_valid), 256'(0));
      check("R11", "reset out_data", out_data, 256'(0));
      check("R11", "reset sticky", 256'(sticky_flags), 256'(0));
      check("R11", "reset undef", 256'(out_undef), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "idle in_ready", 256'(in_ready), 256'(1));

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VECS[i];
         @(negedge clk);
         drive(v);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         if (!v.undef) exp_sticky = exp_sticky | v.flg;
         check(TAGS[i], "out_valid", 256'(out_valid), 256'(1));
         check(TAGS[i], "lane data", 256'(out_data[RES_W-1:0]), 256'(v.expd));
         check("R8", "upper dest bits", 256'(out_data[DEST_W-1:RES_W]), 256'(0));
         check(TAGS[i], "flags", 256'(out_flags), 256'(v.flg));
         check(TAGS[i], "undef", 256'(out_undef), 256'(v.undef));
         check("R11", "sticky", 256'(sticky_flags), 256'(exp_sticky));
      end

      // back-pressure, R10
      @(negedge clk);
      check("R10", "drained", 256'(out_valid), 256'(0));
      out_ready = 1'b0;
      drive(VECS[0]);
      in_valid = 1'b1;
      @(negedge clk);
      check("R10", "in_ready under stall", 256'(in_ready), 256'(0));
      drive(VECS[2]);
      repeat (2) @(negedge clk);
      check("R10", "held valid", 256'(out_valid), 256'(1));
      check("R10", "held data", 256'(out_data[RES_W-1:0]), 256'(VECS[0].expd));
      check("R10", "held flags", 256'(out_flags), 256'(VECS[0].flg));
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", "accept while draining", 256'(out_data[RES_W-1:0]), 256'(VECS[2].expd));
      check("R10", "flags after drain", 256'(out_flags), 256'(VECS[2].flg));
      @(negedge clk);
      check("R10", "empty after take", 256'(out_valid), 256'(0));

      // sticky cleared only by reset, R11
      check("R11", "sticky before reset", 256'(sticky_flags), 256'(exp_sticky));
      rst_n = 1'b0;
      @(negedge clk);
      check("R11", "sticky after reset", 256'(sticky_flags), 256'(0));
      check("R11", "data after reset", out_data, 256'(0));
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule